// File: doc/BRIEF.md
# Two-Word Instruction Prefetch Queue

This block keeps the instruction stream ahead of execution in three 16-bit registers. A fetch-side register receives words from the memory bus. A middle queue register sits behind it. A decode register holds the opcode of the instruction being executed. The fetch-side and middle registers form a two-word queue. An execution controller drives the block with three commands. A fill command primes the queue from a given address, at power-up or after a branch. An advance command ends an instruction. An extension command fetches the extension words of the current instruction.

Extension words never travel through the queue. The block hands each one to the controller on a side port. Only the last word fetched in that stage, which is the next opcode, is written into the fetch-side register. Every instruction then ends with the same three-step advance: fetch-side to middle, one new fetch, middle to decode. The word in the fetch-side register is also given to the controller as the first extension word.

Each bus read lasts at least four clock cycles. A wait state stalls the whole block.

Top module: `pfq_top`

## Requirements
- R1: After reset, `q_ready`, `busy`, `rd_req` and `xw_valid` are low, and no read is issued until a fill command arrives.
- R2: A fill command (`cmd_op` = 2'b01) with address A reads A and then A+2, in that order, and leaves `opcode` = mem[A] and `ext_word` = mem[A+2]. The next read address is A+4.
- R3: An advance command (`cmd_op` = 2'b10) issues exactly one read, at the address just after the word held in `ext_word`. For an instruction with no extension words this is its own address plus 4. Afterwards `opcode` holds the former `ext_word` and `ext_word` holds the word just read.
- R4: When `q_ready` is high, the block is idle with two words held (`opcode` and `ext_word`) and `rd_req` is low.
- R5: Every read holds `rd_req` high for at least MIN_CYC (4) cycles. The word is taken in the first cycle, from the fourth onward, in which `rd_rdy` is high.
- R6: An extension command (`cmd_op` = 2'b11) with count n ≥ 1 reads n consecutive words. The first n−1 words appear in order on `xw_data`, each with a one-cycle `xw_valid` pulse. The last word goes to `ext_word`, and `opcode` does not change.
- R7: An extension command with count 0 issues no read and changes neither `opcode` nor `ext_word`.
- R8: A command that arrives while `busy` is high is ignored. So are advance and extension commands that arrive before the queue holds two words.
- R9: While `rd_rdy` stays low, `rd_req` and `rd_addr` hold steady and `opcode` does not change.
- R10: An instruction with n extension words, run as extension n followed by advance, performs n+1 reads in total, which equals its length in words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 01 fill, 10 advance, 11 extension, 00 none |
| cmd_cnt | input | XCW (3) | Extension word count for the extension command |
| cmd_addr | input | AW (24) | Start byte address for the fill command |
| rd_req | output | 1 | Read request, held until the word is taken |
| rd_addr | output | AW (24) | Byte address of the word being read |
| rd_data | input | DW (16) | Read data |
| rd_rdy | input | 1 | Data ready; low inserts a wait state |
| opcode | output | DW (16) | Decode register |
| ext_word | output | DW (16) | Fetch-side register (first extension word) |
| xw_valid | output | 1 | One-cycle pulse with each bypassed extension word |
| xw_data | output | DW (16) | Bypassed extension word |
| q_ready | output | 1 | Idle with both words held; a new instruction may start |
| busy | output | 1 | A command is in progress |

## Verification
The hardest situation to reach from the ports is a command that lands while a read is stalled or already under way. The queue must then keep its contents and issue no extra read. To get there, the bench holds `rd_rdy` low for a long stretch in the middle of an advance. It also drives an extension command in the cycle right after an advance is accepted. In both cases it checks the read count and the queue words afterwards. The random phase mixes fills at fresh addresses, extension counts from 0 to 4, and random wait states, and it checks every read address against a running model of where the stream should be.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_FILL = 2'b01,
    OP_ADV  = 2'b10,
    OP_EXT  = 2'b11
  } pfq_op_e;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_F1   = 3'd1,
    S_MV1  = 3'd2,
    S_F2   = 3'd3,
    S_MV2  = 3'd4,
    S_XF   = 3'd5
  } pfq_st_e;

  // States in which a bus read is wanted
  function automatic logic wants_read(input pfq_st_e st);
    return (st == S_F1) || (st == S_F2) || (st == S_XF);
  endfunction

  // Extension loop: the final word of the stage goes to the queue
  function automatic logic last_ext(input logic [7:0] left);
    return left == 8'd1;
  endfunction

endpackage

// File: rtl/pfq_addr_ctr.sv
module pfq_addr_ctr #(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic          step,
  output logic [AW-1:0] addr
);
  localparam logic [AW-1:0] STEP = AW'(2);

  always_ff @(posedge clk) begin
    if (!rst_n)     addr <= '0;
    else if (load)  addr <= load_addr;
    else if (step)  addr <= addr + STEP;
  end
endmodule

// File: rtl/pfq_bus_eng.sv
module pfq_bus_eng #(
  parameter int AW      = 24,
  parameter int MIN_CYC = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [AW-1:0] addr_in,
  input  logic          rd_rdy,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  output logic          done
);
  localparam int AGW = $clog2(MIN_CYC + 1);
  localparam logic [AGW-1:0] LAST = AGW'(MIN_CYC - 1);

  logic           active;
  logic [AGW-1:0] age;
  logic [AW-1:0]  addr_q;

  assign done    = active && rd_rdy && (age >= LAST);
  assign rd_req  = active;
  assign rd_addr = addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      age    <= '0;
      addr_q <= '0;
    end else if (go && !active) begin
      active <= 1'b1;
      age    <= '0;
      addr_q <= addr_in;
    end else if (done) begin
      active <= 1'b0;
    end else if (active && (age != LAST)) begin
      age <= age + AGW'(1);
    end
  end

  // R9: a stalled read keeps its request and address
  a_r9_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_rdy) |=> (rd_req && $stable(rd_addr)));
endmodule

// File: rtl/pfq_regs.sv
module pfq_regs #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          ld_irc,
  input  logic [DW-1:0] irc_d,
  input  logic          mv_irc_ir,
  input  logic          mv_ir_ird,
  output logic [DW-1:0] irc,
  output logic [DW-1:0] ir,
  output logic [DW-1:0] ird,
  output logic          irc_v,
  output logic          ir_v,
  output logic          ird_v
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irc <= '0; ir <= '0; ird <= '0;
      irc_v <= 1'b0; ir_v <= 1'b0; ird_v <= 1'b0;
    end else if (clr) begin
      irc_v <= 1'b0; ir_v <= 1'b0; ird_v <= 1'b0;
    end else begin
      if (ld_irc) begin
        irc   <= irc_d;
        irc_v <= 1'b1;
      end else if (mv_irc_ir) begin
        irc_v <= 1'b0;
      end
      if (mv_irc_ir) begin
        ir   <= irc;
        ir_v <= irc_v;
      end else if (mv_ir_ird) begin
        ir_v <= 1'b0;
      end
      if (mv_ir_ird) begin
        ird   <= ir;
        ird_v <= ir_v;
      end
    end
  end

  // R4: the decode register only takes a word that the queue held
  a_r4_ird_from_queue: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_ir_ird && !clr) |=> (ird == $past(ir)));
endmodule

// File: rtl/pfq_seq.sv
module pfq_seq
  import pfq_pkg::*;
#(
  parameter int XCW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_valid,
  input  logic [1:0]     cmd_op,
  input  logic [XCW-1:0] cmd_cnt,
  input  logic           q_full,
  input  logic           bus_done,
  input  logic           bus_active,
  output logic           bus_go,
  output logic           ctr_load,
  output logic           regs_clr,
  output logic           ld_irc,
  output logic           mv1,
  output logic           mv2,
  output logic           xw_fire,
  output logic           busy
);
  pfq_st_e        st, st_n;
  logic [XCW-1:0] left, left_n;
  logic           last_w;

  assign last_w = last_ext(8'(left));
  assign busy   = (st != S_IDLE);
  assign bus_go = wants_read(st) && !bus_active;

  always_comb begin
    st_n     = st;
    left_n   = left;
    ctr_load = 1'b0;
    regs_clr = 1'b0;
    ld_irc   = 1'b0;
    mv1      = 1'b0;
    mv2      = 1'b0;
    xw_fire  = 1'b0;
    case (st)
      S_IDLE: if (cmd_valid) begin
        if (cmd_op == OP_FILL) begin
          ctr_load = 1'b1;
          regs_clr = 1'b1;
          st_n     = S_F1;
        end else if ((cmd_op == OP_ADV) && q_full) begin
          st_n = S_MV1;
        end else if ((cmd_op == OP_EXT) && q_full && (cmd_cnt != '0)) begin
          left_n = cmd_cnt;
          st_n   = S_XF;
        end
      end
      S_F1: if (bus_done) begin
        ld_irc = 1'b1;
        st_n   = S_MV1;
      end
      S_MV1: begin
        mv1  = 1'b1;
        st_n = S_F2;
      end
      S_F2: if (bus_done) begin
        ld_irc = 1'b1;
        st_n   = S_MV2;
      end
      S_MV2: begin
        mv2  = 1'b1;
        st_n = S_IDLE;
      end
      S_XF: if (bus_done) begin
        if (last_w) begin
          ld_irc = 1'b1;
          st_n   = S_IDLE;
        end else begin
          xw_fire = 1'b1;
          left_n  = left - XCW'(1);
        end
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      left <= '0;
    end else begin
      st   <= st_n;
      left <= left_n;
    end
  end

  // R7: an extension command with a zero count leaves the block idle
  a_r7_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && cmd_valid && cmd_op == OP_EXT && cmd_cnt == '0) |=> (st == S_IDLE));
endmodule

// File: rtl/pfq_top.sv
module pfq_top
  import pfq_pkg::*;
#(
  parameter int AW      = 24,
  parameter int DW      = 16,
  parameter int XCW     = 3,
  parameter int MIN_CYC = 4   // at least 4 bus cycles per read
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_valid,
  input  logic [1:0]     cmd_op,
  input  logic [XCW-1:0] cmd_cnt,
  input  logic [AW-1:0]  cmd_addr,
  output logic           rd_req,
  output logic [AW-1:0]  rd_addr,
  input  logic [DW-1:0]  rd_data,
  input  logic           rd_rdy,
  output logic [DW-1:0]  opcode,
  output logic [DW-1:0]  ext_word,
  output logic           xw_valid,
  output logic [DW-1:0]  xw_data,
  output logic           q_ready,
  output logic           busy
);
  localparam logic [AW-1:0] STEP = AW'(2);

  // Named internal events
  logic          bus_go, bus_done;
  logic          ctr_load, regs_clr, ld_irc, mv1, mv2, xw_fire;
  logic [AW-1:0] ctr_addr;
  logic [DW-1:0] irc, ir, ird;
  logic          irc_v, ir_v, ird_v, q_full;

  assign q_full = irc_v && ird_v;

  pfq_seq #(.XCW(XCW)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_cnt(cmd_cnt),
    .q_full(q_full), .bus_done(bus_done), .bus_active(rd_req),
    .bus_go(bus_go), .ctr_load(ctr_load), .regs_clr(regs_clr),
    .ld_irc(ld_irc), .mv1(mv1), .mv2(mv2), .xw_fire(xw_fire), .busy(busy)
  );

  pfq_addr_ctr #(.AW(AW)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load(ctr_load), .load_addr(cmd_addr),
    .step(bus_done), .addr(ctr_addr)
  );

  pfq_bus_eng #(.AW(AW), .MIN_CYC(MIN_CYC)) u_bus (
    .clk(clk), .rst_n(rst_n), .go(bus_go), .addr_in(ctr_addr),
    .rd_rdy(rd_rdy), .rd_req(rd_req), .rd_addr(rd_addr), .done(bus_done)
  );

  pfq_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .clr(regs_clr),
    .ld_irc(ld_irc), .irc_d(rd_data), .mv_irc_ir(mv1), .mv_ir_ird(mv2),
    .irc(irc), .ir(ir), .ird(ird), .irc_v(irc_v), .ir_v(ir_v), .ird_v(ird_v)
  );

  assign opcode   = ird;
  assign ext_word = irc;
  assign q_ready  = !busy && q_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xw_valid <= 1'b0;
      xw_data  <= '0;
    end else begin
      xw_valid <= xw_fire;
      if (xw_fire) xw_data <= rd_data;
    end
  end

  // R4: no read in flight at an instruction boundary
  a_r4_quiet_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    q_ready |-> !rd_req);
  // R5: a read request lasts at least four cycles
  a_r5_min_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_req) |-> ($past(rd_req, 2) && $past(rd_req, 3) && $past(rd_req, 4)));
  // R6: bypassed extension words only come out during a command
  a_r6_xw_in_stage: assert property (@(posedge clk) disable iff (!rst_n)
    xw_valid |-> $past(busy));
  // R8: advance or extension on an unfilled queue does not start
  a_r8_no_start_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !q_full && cmd_valid && (cmd_op == OP_ADV || cmd_op == OP_EXT)) |=> !busy);
  // R2: each completed read moves the address forward by one word
  a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    bus_done |=> (ctr_addr == $past(ctr_addr) + STEP));
endmodule

// File: tb/sim_pfq_top.sv
module sim_pfq_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'b00;
  logic [2:0]  cmd_cnt = 3'd0;
  logic [23:0] cmd_addr = '0;
  logic        rd_req;
  logic [23:0] rd_addr;
  logic [15:0] rd_data;
  logic        rd_rdy = 1'b0;
  logic [15:0] opcode, ext_word, xw_data;
  logic        xw_valid, q_ready, busy;

  always #5 clk = ~clk;

  function automatic logic [15:0] mem_fn(input logic [23:0] a);
    logic [15:0] w;
    w = 16'(a[16:1] * 16'd40503);
    return w ^ {a[23:17], a[8:0]} ^ 16'hA55A;
  endfunction

  assign rd_data = mem_fn(rd_addr);

  pfq_top u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_cnt(cmd_cnt), .cmd_addr(cmd_addr), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_data(rd_data), .rd_rdy(rd_rdy), .opcode(opcode), .ext_word(ext_word),
    .xw_valid(xw_valid), .xw_data(xw_data), .q_ready(q_ready), .busy(busy)
  );

  int n_chk = 0, n_fail = 0;
  int fc = 0, xc = 0, req_len = 0;
  int rdy_mode = 1;          // 0 random, 1 always, 2 never
  bit prev_req = 1'b0;
  bit done_flag = 1'b0;
  logic [23:0] nxt = '0, last_addr = '0;
  logic [23:0] ird_addr = '0, irc_addr = '0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    case (rdy_mode)
      0: rd_rdy = ($urandom % 3) != 0;
      1: rd_rdy = 1'b1;
      default: rd_rdy = 1'b0;
    endcase
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_req && !prev_req) begin
        fc++;
        last_addr = rd_addr;
        chk(rd_addr == nxt, "R2 read address order", rd_addr, nxt);
        nxt = nxt + 24'd2;
        req_len = 0;
      end
      if (rd_req) req_len++;
      if (!rd_req && prev_req) begin
        chk(req_len >= 4, "R5 read length", req_len, 4);
      end
      if (xw_valid) begin
        xc++;
        chk(xw_data == mem_fn(last_addr), "R6 bypassed word", xw_data, mem_fn(last_addr));
      end
      prev_req = rd_req;
    end
  end

  task automatic issue(input logic [1:0] op, input int n, input logic [23:0] a, input bit poke);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_cnt = 3'(n); cmd_addr = a;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'b00;
    if (poke) begin   // R8: command while busy
      cmd_valid = 1'b1; cmd_op = 2'b11; cmd_cnt = 3'd3;
      @(negedge clk);
      cmd_valid = 1'b0; cmd_op = 2'b00;
    end
    while (busy) @(negedge clk);
  endtask

  task automatic do_fill(input logic [23:0] a);
    int f0;
    f0 = fc; nxt = a;
    issue(2'b01, 0, a, 1'b0);
    chk(fc - f0 == 2, "R2 fill read count", fc - f0, 2);
    chk(opcode == mem_fn(a), "R2 fill opcode", opcode, mem_fn(a));
    chk(ext_word == mem_fn(a + 24'd2), "R2 fill ext_word", ext_word, mem_fn(a + 24'd2));
    chk(q_ready == 1'b1, "R4 ready after fill", q_ready, 1);
    ird_addr = a; irc_addr = a + 24'd2;
  endtask

  task automatic do_adv(input bit poke, input bit stall);
    int f0, x0;
    logic [23:0] exp_a;
    logic [15:0] op0;
    f0 = fc; x0 = xc; exp_a = irc_addr + 24'd2; op0 = opcode;
    if (stall) begin
      rdy_mode = 2;
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 2'b10;
      @(negedge clk);
      cmd_valid = 1'b0; cmd_op = 2'b00;
      repeat (20) @(negedge clk);
      chk(rd_req == 1'b1, "R9 request held", rd_req, 1);
      chk(rd_addr == exp_a, "R9 address held", rd_addr, exp_a);
      chk(opcode == op0, "R9 opcode frozen", opcode, op0);
      rdy_mode = 1;
      while (busy) @(negedge clk);
    end else begin
      issue(2'b10, 0, '0, poke);
    end
    chk(fc - f0 == 1, "R3 advance read count", fc - f0, 1);
    chk(last_addr == exp_a, "R3 advance address", last_addr, exp_a);
    chk(opcode == mem_fn(irc_addr), "R3 opcode shift", opcode, mem_fn(irc_addr));
    chk(ext_word == mem_fn(exp_a), "R3 new ext_word", ext_word, mem_fn(exp_a));
    chk(q_ready == 1'b1, "R4 ready at boundary", q_ready, 1);
    if (poke) chk(xc == x0, "R8 busy command ignored", xc - x0, 0);
    ird_addr = irc_addr; irc_addr = exp_a;
  endtask

  task automatic do_ext(input int n);
    int f0, x0;
    logic [15:0] op0, ex0;
    f0 = fc; x0 = xc; op0 = opcode; ex0 = ext_word;
    issue(2'b11, n, '0, 1'b0);
    if (n == 0) begin
      chk(fc == f0, "R7 zero count no read", fc - f0, 0);
      chk(opcode == op0 && ext_word == ex0, "R7 queue unchanged", ext_word, ex0);
    end else begin
      chk(fc - f0 == n, "R6 extension read count", fc - f0, n);
      chk(xc - x0 == n - 1, "R6 bypass count", xc - x0, n - 1);
      chk(opcode == op0, "R6 opcode kept", opcode, op0);
      irc_addr = irc_addr + 24'(2 * n);
      chk(ext_word == mem_fn(irc_addr), "R6 last word queued", ext_word, mem_fn(irc_addr));
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
    finish_run();
  end

  initial begin
    int f0;
    void'($urandom(32'd12345));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!q_ready && !busy && !rd_req && !xw_valid, "R1 reset outputs",
        {q_ready, busy, rd_req, xw_valid}, 0);
    // R8 advance on an empty queue is ignored
    f0 = fc;
    issue(2'b10, 0, '0, 1'b0);
    repeat (8) @(negedge clk);
    chk(fc == f0 && !busy, "R8 empty queue advance", fc - f0, 0);
    chk(fc == 0, "R1 no read before fill", fc, 0);

    do_fill(24'h001000);
    do_adv(1'b0, 1'b0);            // R3 simple instruction: own address + 4
    do_ext(0);
    do_ext(1);
    f0 = fc;
    do_ext(3);
    do_adv(1'b0, 1'b0);
    chk(fc - f0 == 4, "R10 total reads = length", fc - f0, 4);
    do_adv(1'b1, 1'b0);            // R8 busy poke
    do_adv(1'b0, 1'b1);            // R9 stall
    do_fill(24'hFFFFF8);           // address wrap corner

    rdy_mode = 0;
    for (int i = 0; i < 60; i++) begin
      int k;
      k = int'($urandom % 8);
      if (k == 0) do_fill({$urandom % 24'hFFFFFF} & 24'hFFFFFE);
      else if (k < 4) do_adv(1'b0, 1'b0);
      else begin
        int n;
        n = int'($urandom % 5);
        f0 = fc;
        do_ext(n);
        do_adv(1'b0, 1'b0);
        chk(fc - f0 == n + 1, "R10 random length", fc - f0, n + 1);
      end
    end
    rdy_mode = 1;
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule